// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Controller

This block connects a clocked request interface to an external asynchronous 64K x 16 nonvolatile static RAM. The RAM has active-low chip, write and output enables and two active-low byte selects, one for each 8-bit lane. The controller accepts one request at a time through a valid/ready handshake that carries an address, a write flag, write data and an active-high byte mask. It drives the RAM pins, switches its own data driver on and off, samples the returned lanes of a read and hands them back with a single-cycle response pulse.

Every analog timing minimum of the RAM is a nanosecond parameter that is turned into a whole number of clock cycles at elaboration. Each count is ceiling(ns / clock period), and never less than one. After reset a power-up lockout keeps every enable high for a programmable time, 2 ms by default. No request is taken until that time has passed. Writes always keep the output enable high, so the shorter address-to-end-of-write minimum is the one that applies.

Top module: `asram_ctrl`

## Requirements
- R1: After reset release, chip enable, write enable, output enable and both byte selects stay high and `req_ready` stays low. `req_ready` is first seen high after exactly LOCK_CYC+1 rising clock edges, where LOCK_CYC = ceil(LOCK_NS/CLK_NS).
- R2: `req_ready` is high only in the idle state, with every RAM enable high. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is low on the next cycle.
- R3: A read drives chip enable and output enable low, keeps write enable high and sets the byte selects from the mask. Mask bit 0 controls the lower lane (data bits 7:0, select `ram_lb_n`) and mask bit 1 controls the upper lane (bits 15:8, `ram_ub_n`). The data bus is sampled RD_CYC = ceil(access ns / CLK_NS) cycles after the pins change. `rsp_valid` pulses high for exactly one cycle, in the cycle after that sample edge. `rsp_rdata` holds the sampled lanes, and every lane that was not selected reads zero.
- R4: A write drives chip enable and write enable low and output enable high, and turns on the data driver with the write data. Write enable stays low for exactly WR_CYC cycles, the largest of the cycle counts for write-pulse width, data setup and address-to-end-of-write with output enable high.
- R5: After write enable rises, the address, chip enable, the byte selects and the driven data are held for REC_CYC = ceil(recovery ns / CLK_NS) cycles. The data driver is then switched off.
- R6: The data driver is never on while output enable is low. After a read, chip enable and output enable stay high for at least TURN_CYC+1 cycles before the next access begins. TURN_CYC is the largest of the bus-release counts for chip enable and output enable, and is at least one cycle.
- R7: Both byte selects come from one register, so they change on the same edge. A write with a partial mask changes only the selected lanes. A write with mask 00 changes no stored data, and a read with mask 00 returns zero.
- R8: Two address changes that start accesses are at least CYC_CYC = ceil(cycle ns / CLK_NS) cycles apart. Once chip enable returns high it stays high for at least one full cycle.
- R9: Each timing count equals ceil(ns / CLK_NS) with a minimum of one. With the default timing and CLK_NS=10 this gives RD_CYC=4, WR_CYC=2, REC_CYC=2, TURN_CYC=2 and a post-write gap of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Active-high lane mask; bit 0 is the lower lane |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | DATA_W | Read data; lanes that were not selected read zero |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_lb_n | output | 1 | Lower lane select, active low |
| ram_ub_n | output | 1 | Upper lane select, active low |
| ram_dq_out | output | DATA_W | Data the controller drives toward the RAM |
| ram_dq_oe | output | 1 | Enable for the controller's data driver |
| ram_dq_in | input | DATA_W | Data bus as seen from the RAM side |

## Verification
Two things can fall on the same clock edge: the end of the power-up lockout and a request that has been waiting. The bench raises a write request before reset is released and holds it through the whole lockout. It then checks that no RAM enable moves early, that ready appears on the expected edge, and that the held write is taken exactly once on the first idle edge. A second collision is the read sample edge, where the response pulse and the rising edges of chip enable and output enable happen together. The RAM model in the bench returns junk until the access time has passed and drives a fixed pattern on lanes that are not selected. A sample taken one cycle early, or lane masking that is missing, therefore shows up as a scoreboard mismatch.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_IDLE,
        ST_RD,
        ST_RD_REL,
        ST_WR,
        ST_WR_REC,
        ST_GAP
    } seq_state_e;

    // ceiling(ns / clk_ns), never below one cycle (R9)
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned usub(input int unsigned a, input int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/asram_lockout.sv
`timescale 1ns/1ps
module asram_lockout #(
    parameter int unsigned LOCK_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CW = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (!lk_q.done) begin
            lk_d.cnt  = lk_q.cnt + 1'b1;
            lk_d.done = (lk_q.cnt == CW'(LOCK_CYC - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign done = lk_q.done;
endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
module asram_lanes #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W/8-1:0] sel_n,
    input  logic [DATA_W-1:0]   dq_in,
    output logic [DATA_W-1:0]   masked
);
    localparam int unsigned LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*8 +: 8] = sel_n[l] ? 8'h00 : dq_in[l*8 +: 8];
    end
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq import asram_pkg::*; #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned RD_CYC   = 4,
    parameter int unsigned TURN_CYC = 2,
    parameter int unsigned WR_CYC   = 2,
    parameter int unsigned REC_CYC  = 2,
    parameter int unsigned GAP_CYC  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lock_done,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     rd_lanes,
    output logic [DATA_W/8-1:0]   sel_n,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic                  ram_ce_n,
    output logic                  ram_we_n,
    output logic                  ram_oe_n,
    output logic                  ram_dq_oe,
    output logic [DATA_W-1:0]     ram_dq_out,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned CNT_MAX = umax(umax(umax(RD_CYC, TURN_CYC), umax(WR_CYC, REC_CYC)), GAP_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LANES-1:0]   sel_n;
        logic               ce_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic               rsp_v;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    wire last_cyc = (s_q.cnt == CNT_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        unique case (s_q.st)
            ST_LOCK: begin
                if (lock_done) s_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr  = req_addr;
                    s_d.sel_n = ~req_be;
                    s_d.ce_n  = 1'b0;
                    if (req_write) begin
                        s_d.st    = ST_WR;
                        s_d.cnt   = CNT_W'(WR_CYC);
                        s_d.we_n  = 1'b0;
                        s_d.oe_n  = 1'b1;
                        s_d.dq_oe = 1'b1;
                        s_d.wdata = req_wdata;
                    end else begin
                        s_d.st    = ST_RD;
                        s_d.cnt   = CNT_W'(RD_CYC);
                        s_d.oe_n  = 1'b0;
                    end
                end
            end
            ST_RD: begin
                if (last_cyc) begin
                    s_d.rsp_v = 1'b1;
                    s_d.rdata = rd_lanes;
                    s_d.ce_n  = 1'b1;
                    s_d.oe_n  = 1'b1;
                    s_d.sel_n = '1;
                    s_d.cnt   = CNT_W'(TURN_CYC);
                    s_d.st    = ST_RD_REL;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WR: begin
                if (last_cyc) begin
                    s_d.we_n = 1'b1;
                    s_d.cnt  = CNT_W'(REC_CYC);
                    s_d.st   = ST_WR_REC;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WR_REC: begin
                if (last_cyc) begin
                    s_d.ce_n  = 1'b1;
                    s_d.sel_n = '1;
                    s_d.dq_oe = 1'b0;
                    s_d.cnt   = CNT_W'(GAP_CYC);
                    s_d.st    = ST_GAP;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RD_REL, ST_GAP: begin
                if (last_cyc) s_d.st = ST_IDLE;
                else          s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_LOCK;
            s_q.sel_n <= '1;
            s_q.ce_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign sel_n      = s_q.sel_n;
    assign ram_addr   = s_q.addr;
    assign ram_ce_n   = s_q.ce_n;
    assign ram_we_n   = s_q.we_n;
    assign ram_oe_n   = s_q.oe_n;
    assign ram_dq_oe  = s_q.dq_oe;
    assign ram_dq_out = s_q.wdata;
    assign rsp_valid  = s_q.rsp_v;
    assign rsp_rdata  = s_q.rdata;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl import asram_pkg::*; #(
    parameter int unsigned CLK_NS          = 10,
    parameter int unsigned LOCK_NS         = 2000000,
    parameter int unsigned ADDR_W          = 16,
    parameter int unsigned DATA_W          = 16,
    parameter int unsigned T_CYCLE_NS      = 35,
    parameter int unsigned T_ACCESS_NS     = 35,
    parameter int unsigned T_WPULSE_NS     = 15,
    parameter int unsigned T_DSETUP_NS     = 10,
    parameter int unsigned T_ADDR_END_NS   = 18,
    parameter int unsigned T_RECOVER_NS    = 12,
    parameter int unsigned T_HIGH_NS       = 2,
    parameter int unsigned T_CE_RELEASE_NS = 15,
    parameter int unsigned T_OE_RELEASE_NS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                ram_ce_n,
    output logic                ram_we_n,
    output logic                ram_oe_n,
    output logic                ram_lb_n,
    output logic                ram_ub_n,
    output logic [DATA_W-1:0]   ram_dq_out,
    output logic                ram_dq_oe,
    input  logic [DATA_W-1:0]   ram_dq_in
);
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned LOCK_CYC = ns_to_cyc(LOCK_NS, CLK_NS);
    localparam int unsigned CYC_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
    localparam int unsigned RD_CYC   = ns_to_cyc(T_ACCESS_NS, CLK_NS);
    localparam int unsigned HI_CYC   = ns_to_cyc(T_HIGH_NS, CLK_NS);
    localparam int unsigned TURN_CYC = umax(umax(ns_to_cyc(T_CE_RELEASE_NS, CLK_NS),
                                                 ns_to_cyc(T_OE_RELEASE_NS, CLK_NS)),
                                            umax(HI_CYC, usub(CYC_CYC, RD_CYC + 1)));
    localparam int unsigned WR_CYC   = umax(umax(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                                                 ns_to_cyc(T_DSETUP_NS, CLK_NS)),
                                            ns_to_cyc(T_ADDR_END_NS, CLK_NS));
    localparam int unsigned REC_CYC  = ns_to_cyc(T_RECOVER_NS, CLK_NS);
    localparam int unsigned GAP_CYC  = umax(HI_CYC, usub(CYC_CYC, WR_CYC + REC_CYC + 1));

    logic             lock_done;
    logic [LANES-1:0] sel_n;
    logic [DATA_W-1:0] rd_lanes;

    asram_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (lock_done)
    );

    asram_lanes #(.DATA_W(DATA_W)) u_lanes (
        .sel_n  (sel_n),
        .dq_in  (ram_dq_in),
        .masked (rd_lanes)
    );

    asram_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WR_CYC   (WR_CYC),
        .REC_CYC  (REC_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_done  (lock_done),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .rd_lanes   (rd_lanes),
        .sel_n      (sel_n),
        .ram_addr   (ram_addr),
        .ram_ce_n   (ram_ce_n),
        .ram_we_n   (ram_we_n),
        .ram_oe_n   (ram_oe_n),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_out (ram_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    assign ram_lb_n = sel_n[0];
    assign ram_ub_n = sel_n[LANES-1];
endmodule

// File: rtl/asram_chk.sv
`timescale 1ns/1ps
module asram_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned LOCK_CYC = 200000,
    parameter int unsigned WR_CYC   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              ram_lb_n,
    input logic              ram_ub_n,
    input logic              ram_dq_oe
);
    localparam int unsigned LW = $clog2(LOCK_CYC + 2);

    logic [LW-1:0] lk_cnt;
    logic [7:0]    we_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_cnt <= '0;
            we_run <= '0;
        end else begin
            if (lk_cnt < LW'(LOCK_CYC)) lk_cnt <= lk_cnt + 1'b1;
            we_run <= ram_we_n ? 8'd0 : we_run + 8'd1;
        end
    end

    assert_lock_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_cnt < LW'(LOCK_CYC)) |-> (ram_ce_n && ram_we_n && !req_ready));

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n));

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_write_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_oe_n && ram_dq_oe));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_run >= 8'(WR_CYC)));

    assert_rec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ($stable(ram_addr) && !ram_ce_n && ram_dq_oe));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    assert_sel_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ram_lb_n) && !ram_ub_n) |-> $fell(ram_ub_n));

    assert_ce_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_ce_n) |=> ram_ce_n);
endmodule

bind asram_ctrl asram_chk #(
    .ADDR_W   (ADDR_W),
    .LOCK_CYC (LOCK_CYC),
    .WR_CYC   (WR_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_lb_n  (ram_lb_n),
    .ram_ub_n  (ram_ub_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK_NS    = 3000;
    localparam int LOCK_C     = (LOCK_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RD_C       = 4;   // ceil(35/10)
    localparam int WR_C       = 2;   // max(ceil 15/10, ceil 10/10, ceil 18/10)
    localparam int REC_C      = 2;   // ceil(12/10)
    localparam int TURN_C     = 2;   // ceil(15/10)
    localparam int GAP_C      = 1;   // ceil(2/10) min 1
    localparam int CYC_C      = 4;   // ceil(35/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] ram_addr;
    logic        ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
    logic [15:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [15:0] ram_dq_in = 16'h5A5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl #(.CLK_NS(CLK_PERIOD), .LOCK_NS(LOCK_NS)) u_asram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // ---------------- RAM model ----------------
    logic [15:0] ram_mem [int];
    realtime     last_evt = 0.0;

    always @(ram_addr or ram_ce_n or ram_oe_n or ram_lb_n or ram_ub_n) last_evt = $realtime;

    always @(posedge ram_we_n) begin
        if (rst_n && !ram_ce_n && ram_dq_oe) begin
            logic [15:0] cur;
            cur = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0000;
            if (!ram_lb_n) cur[7:0]  = ram_dq_out[7:0];
            if (!ram_ub_n) cur[15:8] = ram_dq_out[15:8];
            ram_mem[int'(ram_addr)] = cur;
        end
    end

    always begin
        #1;
        if (!ram_ce_n && !ram_oe_n && ram_we_n) begin
            logic [15:0] word;
            word = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0000;
            if ($realtime - last_evt < 35.0) ram_dq_in = 16'hDEAD;
            else ram_dq_in = {ram_ub_n ? 8'hA5 : word[15:8], ram_lb_n ? 8'hA5 : word[7:0]};
        end else begin
            ram_dq_in = 16'h5A5A;
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] shadow [int];
    logic [15:0] exp_q [$];

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {be[1] ? 8'hFF : 8'h00, be[0] ? 8'hFF : 8'h00};
    endfunction

    function automatic void shadow_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] cur;
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        shadow[int'(a)] = (cur & ~lane_mask(be)) | (d & lane_mask(be));
    endfunction

    task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (wr) shadow_write(a, d, be);
        else exp_q.push_back((shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000) & lane_mask(be));
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low after accept", 32'(req_ready), 0);
    endtask

    // ---------------- pin monitor ----------------
    int cyc = 0, last_addr_cyc = 0, we_low_run = 0, we_rise_cyc = 0, oe_fall_cyc = 0, ce_high_run = 0;
    bit have_addr = 0, last_was_read = 0;
    logic [15:0] prev_addr = '0;
    logic prev_we = 1, prev_oe = 1, prev_ce = 1, prev_dq_oe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ram_addr != prev_addr) begin
                if (have_addr) chk(cyc - last_addr_cyc >= CYC_C, "R8 address spacing", 32'(cyc - last_addr_cyc), CYC_C);
                last_addr_cyc = cyc; have_addr = 1;
            end
            if (!ram_we_n) begin
                we_low_run++;
                chk(!ram_ce_n && ram_oe_n && ram_dq_oe, "R4 write pins", {ram_ce_n, ram_oe_n, ram_dq_oe}, 3'b011);
            end else if (!prev_we) begin
                chk(we_low_run == WR_C, "R4 write pulse cycles", 32'(we_low_run), WR_C);
                we_rise_cyc = cyc; we_low_run = 0;
            end
            if (prev_dq_oe && !ram_dq_oe)
                chk(cyc - we_rise_cyc == REC_C, "R5 recovery hold", 32'(cyc - we_rise_cyc), REC_C);
            if (ram_dq_oe)
                chk(ram_oe_n, "R6 driver with output enable low", 32'(ram_oe_n), 1);
            if (prev_oe && !ram_oe_n) oe_fall_cyc = cyc;
            if (ram_ce_n) ce_high_run++;
            else begin
                if (prev_ce) begin
                    chk(ce_high_run >= (last_was_read ? TURN_C + 1 : GAP_C + 1), "R6 R8 enable high gap",
                        32'(ce_high_run), last_was_read ? TURN_C + 1 : GAP_C + 1);
                    last_was_read = !ram_oe_n;
                end
                ce_high_run = 0;
            end
            if (rsp_valid) begin
                chk(cyc - oe_fall_cyc == RD_C, "R3 read sample delay", 32'(cyc - oe_fall_cyc), RD_C);
                if (exp_q.size() == 0) chk(0, "R3 unexpected response", 32'(rsp_rdata), 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R3 R7 read data", 32'(rsp_rdata), 32'(e));
                end
            end
            prev_addr = ram_addr; prev_we = ram_we_n; prev_oe = ram_oe_n;
            prev_ce = ram_ce_n; prev_dq_oe = ram_dq_oe;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, req_ready} == 6'b111110,
            "R1 reset state", {ram_ce_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, req_ready}, 6'b111110);
        rst_n = 1'b1;
        // request waiting through the whole lockout
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0010; req_wdata = 16'h1234; req_be = 2'b11;
        shadow_write(16'h0010, 16'h1234, 2'b11);
        n = 0;
        while (!req_ready) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!req_ready) begin
                if (!ram_ce_n || !ram_we_n) chk(0, "R1 enable moved in lockout", {ram_ce_n, ram_we_n}, 2'b11);
            end
        end
        chk(n == LOCK_C + 1, "R1 lockout length", 32'(n), LOCK_C + 1);
        chk(ram_ce_n && ram_we_n, "R1 enables still high at ready", {ram_ce_n, ram_we_n}, 2'b11);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ram_ce_n && !ram_we_n, "R2 held request taken on first idle edge", {ram_ce_n, ram_we_n}, 2'b00);
        chk(!req_ready, "R2 ready low after accept", 32'(req_ready), 0);

        do_req(0, 16'h0010, 16'h0000, 2'b11);          // R3 full word read
        do_req(1, 16'h0020, 16'hABCD, 2'b01);          // R7 lower lane only
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        do_req(1, 16'h0020, 16'h5600, 2'b10);          // R7 upper lane only
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        do_req(0, 16'h0020, 16'h0000, 2'b10);          // R3 unselected lane zero
        do_req(0, 16'h0020, 16'h0000, 2'b01);
        do_req(1, 16'h0020, 16'hFFFF, 2'b00);          // R7 empty mask write
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        do_req(0, 16'h0020, 16'h0000, 2'b00);          // R7 empty mask read
        do_req(1, 16'hFFFF, 16'hBEEF, 2'b11);
        do_req(0, 16'hFFFF, 16'h0000, 2'b11);
        for (int i = 0; i < 24; i++) begin
            do_req(1, 16'(i * 977 + 3), 16'(i * 16'h1357) ^ 16'hA0A0, 2'(i % 4));
            do_req(0, 16'(i * 977 + 3), 16'h0000, 2'(3 - (i % 4)));
            do_req(0, 16'(i * 977 + 3), 16'h0000, 2'b11);
        end
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all responses returned", 32'(exp_q.size()), 0);
        summary();
        $finish;
    end
endmodule